// File: doc/BRIEF.md
# ADC Interrupt Status Flag Register

This block holds the 32-bit read-only status word of a multi-channel analog-to-digital converter controller. It collects event strobes from the conversion sequencer, from the calibration engine, from the overrun and window-comparison detectors, and level signals from a receive DMA channel. It turns them into flags that software reads from one word. A masked OR of that word drives one interrupt line.

Each flag is cleared by its own source, not by one shared clear scheme:
- A per-channel end-of-conversion flag is cleared by reading that channel's data register.
- The data-ready flag is cleared by reading the last-converted-data register.
- The overrun and comparison-error flags are cleared by reading the status word itself.
- The calibration-done flag is cleared by a new calibration request.
- The two DMA bits are not stored. They follow their input levels.

The status word is combinational from the stored flags and the live inputs. A read strobe sees the current value in its own cycle, and any clear it causes shows from the next cycle.

Top module: `adc_status_word`

## Requirements
- R1: Bit layout of `status`:
  - bits NCH-1..0: end-of-conversion flags, with bit n for channel n
  - bit 23: calibration done
  - bit 24: data ready
  - bit 25: overrun
  - bit 26: comparison error
  - bit 27: receive-transfer-end level
  - bit 28: receive-buffer-full level
  - every other bit reads 0.
- R2: A `conv_done` pulse with `conv_chan` = n, while `chan_en[n]` is 1, sets the flag of channel n. The flag is visible from the cycle after the pulse. A pulse for a disabled channel changes nothing.
- R3: A channel's end-of-conversion bit reads 0 in any cycle where its `chan_en` bit is 0. A cycle spent disabled discards the stored flag, so re-enabling the channel shows 0.
- R4: A `rd_chan` pulse with `rd_chan_sel` = n clears only channel n's flag, from the next cycle on. The other channels keep their flags.
- R5: Data ready sets on any accepted conversion (as defined in R2). It clears on an `rd_last` pulse.
- R6: Overrun and comparison error are sticky. Each sets on its event pulse and clears on an `rd_status` pulse. The status value read during that pulse still shows the flag.
- R7: Calibration done clears on `cal_start` and sets on `cal_finish`. It holds in between. It is 0 after reset.
- R8: Bits 27 and 28 equal `dma_end_lvl` and `dma_full_lvl` in the same cycle.
- R9: When a set event and a clear event hit the same flag in the same cycle, the flag ends up set. This covers `cal_finish` together with `cal_start`.
- R10: `irq` is 1 exactly when `status & irq_mask` is nonzero. It is combinational.
- R11: Asserting `rst_n` low clears every stored flag at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | NCH | Channel enable mask |
| conv_done | input | 1 | Conversion-complete pulse |
| conv_chan | input | CHW | Channel of the completed conversion |
| cal_start | input | 1 | Calibration request pulse |
| cal_finish | input | 1 | Calibration sequence finished pulse |
| ovr_evt | input | 1 | General overrun event pulse |
| cmp_evt | input | 1 | Window comparison event pulse |
| dma_end_lvl | input | 1 | Receive DMA end-of-transfer level |
| dma_full_lvl | input | 1 | Receive DMA buffer-full level |
| rd_status | input | 1 | Status word read strobe |
| rd_chan | input | 1 | Channel data register read strobe |
| rd_chan_sel | input | CHW | Channel whose data register is read |
| rd_last | input | 1 | Last-converted-data register read strobe |
| irq_mask | input | 32 | Interrupt enable mask, same layout as status |
| status | output | 32 | Status word |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets the following corner cases:
- **Same-cycle collisions between a set and its clear.** A design that let the clear win would lose a conversion or an overrun that lands on the very read meant to acknowledge the previous one.
- **Conversions and reads for disabled channels, and enable bits dropping while a flag is held.** A design that stored flags for disabled channels would show stale completions after re-enable. One that decoded the read channel wrongly would wipe a neighbour's flag.
- **Reads of the status word while a sticky flag is set.** A design that cleared too early would hide the very event being read.
- **Toggling of the DMA levels and the interrupt mask.** Any registering on these paths would show up as a one-cycle lag against the reference model.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Bit positions inside the status word; software decodes them.
    localparam int unsigned STAT_W      = 32;
    localparam int unsigned MAX_CHANS   = 16;
    localparam int unsigned POS_CALDONE = 23;
    localparam int unsigned POS_DRDY    = 24;
    localparam int unsigned POS_OVR     = 25;
    localparam int unsigned POS_CMP     = 26;
    localparam int unsigned POS_RXEND   = 27;
    localparam int unsigned POS_RXFULL  = 28;

    // Latched non-channel flags.
    typedef struct packed {
        logic caldone;
        logic drdy;
        logic ovr;
        logic cmp;
    } evt_flags_t;

endpackage

// File: rtl/adc_eoc_bank.sv
module adc_eoc_bank #(
    parameter int unsigned NCH = 16,
    parameter int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_en,
    input  logic           conv_vld,
    input  logic [CHW-1:0] conv_chan,
    input  logic           rd_vld,
    input  logic [CHW-1:0] rd_sel,
    output logic [NCH-1:0] eoc_o,
    output logic           accept_o
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [NCH-1:0] eoc;
    } eoc_state_t;

    eoc_state_t     st_d, st_q;
    logic [NCH-1:0] set_hit;
    logic [NCH-1:0] clr_hit;

    // One decode per channel for the conversion and read strobes.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
        assign set_hit[ch] = conv_vld && (conv_chan == CHW'(ch)) && chan_en[ch];
        assign clr_hit[ch] = rd_vld && (rd_sel == CHW'(ch));
    end

    always_comb begin
        st_d = st_q;
        for (int ch = 0; ch < NCH; ch++) begin
            if (!chan_en[ch]) begin
                st_d.eoc[ch] = 1'b0;
            end else if (set_hit[ch]) begin
                st_d.eoc[ch] = 1'b1;
            end else if (clr_hit[ch]) begin
                st_d.eoc[ch] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eoc_o    = st_q.eoc & chan_en;
    assign accept_o = |set_hit;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        // R2: an accepted conversion is stored
        p_conv_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (conv_vld && conv_chan == CHW'(ch) && chan_en[ch]) |=> st_q.eoc[ch]);
        // R3: a disabled cycle discards the stored flag
        p_disable_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_en[ch] |=> !st_q.eoc[ch]);
        // R4: a read without a same-cycle set clears the flag
        p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_vld && rd_sel == CHW'(ch) &&
             !(conv_vld && conv_chan == CHW'(ch))) |=> !st_q.eoc[ch]);
        // R4: a read of another channel leaves this one alone
        p_read_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.eoc[ch] && chan_en[ch] && rd_vld && rd_sel != CHW'(ch)) |=> st_q.eoc[ch]);
        // R9: set wins over a same-cycle read
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (conv_vld && conv_chan == CHW'(ch) && chan_en[ch] &&
             rd_vld && rd_sel == CHW'(ch)) |=> st_q.eoc[ch]);
    end

endmodule

// File: rtl/adc_evt_flags.sv
module adc_evt_flags
    import adc_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_accept,
    input  logic       rd_last,
    input  logic       rd_status,
    input  logic       ovr_evt,
    input  logic       cmp_evt,
    input  logic       cal_start,
    input  logic       cal_finish,
    output evt_flags_t flags_o
);
    timeunit 1ns;
    timeprecision 1ps;

    evt_flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;

        // Data ready: set by a result, cleared by the last-data read.
        if (conv_accept) begin
            fl_d.drdy = 1'b1;
        end else if (rd_last) begin
            fl_d.drdy = 1'b0;
        end

        // Sticky error flags: cleared by reading the status word.
        if (ovr_evt) begin
            fl_d.ovr = 1'b1;
        end else if (rd_status) begin
            fl_d.ovr = 1'b0;
        end

        if (cmp_evt) begin
            fl_d.cmp = 1'b1;
        end else if (rd_status) begin
            fl_d.cmp = 1'b0;
        end

        // Calibration done: a new request withdraws it.
        if (cal_finish) begin
            fl_d.caldone = 1'b1;
        end else if (cal_start) begin
            fl_d.caldone = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags_o = fl_q;

    // R5: data ready follows results and last-data reads
    p_drdy_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_accept |=> fl_q.drdy);
    p_drdy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_last && !conv_accept) |=> !fl_q.drdy);
    // R6: sticky until a status read
    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.ovr && !rd_status) |=> fl_q.ovr);
    p_cmp_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.cmp && !rd_status) |=> fl_q.cmp);
    p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !ovr_evt) |=> !fl_q.ovr);
    // R7: calibration request withdraws the done flag
    p_cal_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_start && !cal_finish) |=> !fl_q.caldone);
    p_cal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_start && !cal_finish) |=> $stable(fl_q.caldone));
    // R9: set wins over a same-cycle clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && rd_status) |=> fl_q.ovr);
    p_cal_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_finish && cal_start) |=> fl_q.caldone);

endmodule

// File: rtl/adc_irq_merge.sv
module adc_irq_merge #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W-1:0] hits;

    assign hits  = status_i & mask_i;
    assign irq_o = |hits;

endmodule

// File: rtl/adc_status_word.sv
module adc_status_word
    import adc_stat_pkg::*;
#(
    parameter int unsigned NCH = 16,
    parameter int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_en,
    input  logic           conv_done,
    input  logic [CHW-1:0] conv_chan,
    input  logic           cal_start,
    input  logic           cal_finish,
    input  logic           ovr_evt,
    input  logic           cmp_evt,
    input  logic           dma_end_lvl,
    input  logic           dma_full_lvl,
    input  logic           rd_status,
    input  logic           rd_chan,
    input  logic [CHW-1:0] rd_chan_sel,
    input  logic           rd_last,
    input  logic [31:0]    irq_mask,
    output logic [31:0]    status,
    output logic           irq
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [NCH-1:0] eoc_vis;
    logic           conv_accept;
    evt_flags_t     flags;
    logic [31:0]    word;

    adc_eoc_bank #(
        .NCH (NCH),
        .CHW (CHW)
    ) u_eoc (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .conv_vld  (conv_done),
        .conv_chan (conv_chan),
        .rd_vld    (rd_chan),
        .rd_sel    (rd_chan_sel),
        .eoc_o     (eoc_vis),
        .accept_o  (conv_accept)
    );

    adc_evt_flags u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_accept (conv_accept),
        .rd_last     (rd_last),
        .rd_status   (rd_status),
        .ovr_evt     (ovr_evt),
        .cmp_evt     (cmp_evt),
        .cal_start   (cal_start),
        .cal_finish  (cal_finish),
        .flags_o     (flags)
    );

    // Pack the word; unlisted bits stay zero.
    always_comb begin
        word                = '0;
        word[NCH-1:0]       = eoc_vis;
        word[POS_CALDONE]   = flags.caldone;
        word[POS_DRDY]      = flags.drdy;
        word[POS_OVR]       = flags.ovr;
        word[POS_CMP]       = flags.cmp;
        word[POS_RXEND]     = dma_end_lvl;
        word[POS_RXFULL]    = dma_full_lvl;
    end

    assign status = word;

    adc_irq_merge #(
        .W (32)
    ) u_irq (
        .status_i (word),
        .mask_i   (irq_mask),
        .irq_o    (irq)
    );

    // R6: the value returned by a status read still carries the overrun
    p_read_sees_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> status[POS_OVR]);
    // R10: an enabled overrun raises the interrupt
    p_irq_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && $rose(1'b1) == 1'b0) |=> (irq_mask[POS_OVR] -> irq));

endmodule

// File: tb/sim_adc_status_word.sv
module sim_adc_status_word;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned NCH = 16;
    localparam int unsigned CHW = 4;
    localparam logic [31:0] RSVD = ~(32'h1F80_0000 | 32'h0000_FFFF);
    localparam logic [31:0] LATCHED = 32'h0780_FFFF;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n;
    logic [NCH-1:0] chan_en;
    logic           conv_done;
    logic [CHW-1:0] conv_chan;
    logic           cal_start, cal_finish, ovr_evt, cmp_evt;
    logic           dma_end_lvl, dma_full_lvl;
    logic           rd_status, rd_chan, rd_last;
    logic [CHW-1:0] rd_chan_sel;
    logic [31:0]    irq_mask;
    logic [31:0]    status;
    logic           irq;

    adc_status_word #(.NCH(NCH), .CHW(CHW)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .conv_done(conv_done),
        .conv_chan(conv_chan), .cal_start(cal_start), .cal_finish(cal_finish),
        .ovr_evt(ovr_evt), .cmp_evt(cmp_evt), .dma_end_lvl(dma_end_lvl),
        .dma_full_lvl(dma_full_lvl), .rd_status(rd_status), .rd_chan(rd_chan),
        .rd_chan_sel(rd_chan_sel), .rd_last(rd_last), .irq_mask(irq_mask),
        .status(status), .irq(irq)
    );

    // Behavioural reference state
    bit   m_eoc [NCH];
    bit   m_drdy, m_ovr, m_cmp, m_cal;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2468;

    task automatic model_reset();
        foreach (m_eoc[i]) m_eoc[i] = 1'b0;
        m_drdy = 0; m_ovr = 0; m_cmp = 0; m_cal = 0;
    endtask

    function automatic logic [31:0] expected();
        logic [31:0] e = 32'h0;
        for (int i = 0; i < NCH; i++) e[i] = m_eoc[i] && chan_en[i];
        e[23] = m_cal;  e[24] = m_drdy; e[25] = m_ovr; e[26] = m_cmp;
        e[27] = dma_end_lvl; e[28] = dma_full_lvl;
        return e;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [31:0] e = expected();
        check("R2 R3 R4 R9 eoc", {16'h0, status[15:0]}, {16'h0, e[15:0]});
        check("R7 caldone", {31'h0, status[23]}, {31'h0, e[23]});
        check("R5 drdy", {31'h0, status[24]}, {31'h0, e[24]});
        check("R6 ovr/cmp", {30'h0, status[26:25]}, {30'h0, e[26:25]});
        check("R8 rx mirror", {30'h0, status[28:27]}, {30'h0, e[28:27]});
        check("R1 reserved", status & RSVD, 32'h0);
        check("R10 irq", {31'h0, irq}, {31'h0, |(e & irq_mask)});
    endtask

    // Applied on the rising edge with the inputs driven in the preceding low phase.
    task automatic model_step();
        bit acc = 1'b0;
        if (!rst_n) return;
        for (int i = 0; i < NCH; i++) begin
            if (!chan_en[i]) m_eoc[i] = 1'b0;
            else if (conv_done && conv_chan == CHW'(i)) begin m_eoc[i] = 1'b1; acc = 1'b1; end
            else if (rd_chan && rd_chan_sel == CHW'(i)) m_eoc[i] = 1'b0;
        end
        if (acc) m_drdy = 1; else if (rd_last) m_drdy = 0;
        if (ovr_evt) m_ovr = 1; else if (rd_status) m_ovr = 0;
        if (cmp_evt) m_cmp = 1; else if (rd_status) m_cmp = 0;
        if (cal_finish) m_cal = 1; else if (cal_start) m_cal = 0;
    endtask

    task automatic tick();
        #1 compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic quiet();
        conv_done = 0; cal_start = 0; cal_finish = 0; ovr_evt = 0; cmp_evt = 0;
        rd_status = 0; rd_chan = 0; rd_last = 0;
    endtask

    initial begin
        rst_n = 0; chan_en = '0; conv_chan = '0; rd_chan_sel = '0;
        dma_end_lvl = 0; dma_full_lvl = 0; irq_mask = '0;
        quiet();
        model_reset();
        repeat (3) @(negedge clk);
        #1 check("R11 reset word", status, 32'h0);
        check("R11 reset irq", {31'h0, irq}, 32'h0);
        rst_n = 1;
        irq_mask = 32'hFFFF_FFFF;
        tick();

        // R2: enabled channel accepted, disabled channel ignored
        chan_en = 16'h8009;
        conv_done = 1; conv_chan = 4'd3; tick();
        conv_chan = 4'd5; tick();
        quiet(); tick();
        // R4: read of channel 0 leaves channel 3; read of 3 clears it
        rd_chan = 1; rd_chan_sel = 4'd0; tick();
        rd_chan_sel = 4'd3; tick();
        quiet(); tick();
        // R9: conversion and read of same channel together
        conv_done = 1; conv_chan = 4'd15; rd_chan = 1; rd_chan_sel = 4'd15; tick();
        quiet(); tick();
        // R3: disable and re-enable channel 15
        chan_en = 16'h0009; tick();
        chan_en = 16'h8009; tick();
        // R5: last-data read clears data ready
        rd_last = 1; tick();
        quiet(); tick();
        // R6 and R9: sticky errors and same-cycle read
        ovr_evt = 1; tick();
        ovr_evt = 0; cmp_evt = 1; tick();
        quiet(); tick(); tick();
        rd_status = 1; tick();
        quiet(); tick();
        ovr_evt = 1; rd_status = 1; tick();
        quiet(); tick();
        // R7 and R9: calibration sequence
        cal_finish = 1; tick();
        quiet(); cal_start = 1; tick();
        quiet(); tick();
        cal_start = 1; cal_finish = 1; tick();
        quiet(); tick();
        // R8 and R10: live levels and masking
        irq_mask = 32'h0800_0000; tick();
        dma_end_lvl = 1; tick();
        dma_full_lvl = 1; dma_end_lvl = 0; tick();
        irq_mask = 32'h1000_0000; tick();
        irq_mask = 32'h0; tick();

        // Mixed traffic
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            conv_done   = lfsr[0] | lfsr[9];
            conv_chan   = lfsr[4:1];
            rd_chan     = lfsr[5];
            rd_chan_sel = lfsr[13:10];
            rd_last     = lfsr[6] & lfsr[14];
            rd_status   = lfsr[7] & lfsr[15];
            ovr_evt     = lfsr[8] & lfsr[16] & lfsr[17];
            cmp_evt     = lfsr[18] & lfsr[19] & lfsr[20];
            cal_start   = lfsr[21] & lfsr[22];
            cal_finish  = lfsr[23] & lfsr[24];
            dma_end_lvl = lfsr[25];
            dma_full_lvl = lfsr[26];
            if (lfsr[27:24] == 4'hF) chan_en = chan_en ^ (16'h1 << lfsr[31:28]);
            if (lfsr[30:27] == 4'h0) irq_mask = {lfsr[15:0], lfsr[31:16]};
            tick();
        end

        // R11: reset mid-run clears stored flags at once
        quiet();
        chan_en = 16'hFFFF; ovr_evt = 1; cmp_evt = 1; cal_finish = 1;
        conv_done = 1; conv_chan = 4'd7; tick();
        quiet();
        rst_n = 0; model_reset();
        #1 check("R11 mid-run reset", status & LATCHED, 32'h0);
        @(negedge clk);
        rst_n = 1;
        tick(); tick();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule